// File: doc/BRIEF.md
# Exact-Coverage Triangle Tile Binner

This block takes one screen-space triangle at a time and produces the list of 32x32-pixel screen tiles that the triangle overlaps. Each vertex is an unsigned fixed-point coordinate with four fractional bits. The triangle also carries a primitive index. The block first narrows the search to the tiles under the triangle's bounding box, clamped to a 64x64 tile grid. It then walks those candidate tiles in raster order, one per cycle. Each candidate is tested against the triangle's three edge functions, and only the tiles that pass produce a record.

A record holds the tile column, the tile row and the primitive index. Triangles arrive on a valid/ready handshake, and records leave on another valid/ready handshake. A one-cycle completion pulse marks the end of each triangle's list. A following stage can use the records to build per-tile primitive lists.

The orientation of the vertices does not matter, because the block normalises the winding before it tests any tile. Triangles with zero area produce no records, and so do triangles that lie wholly outside the grid.

Top module: `tri_tile_binner`

## Requirements
- R1: A vertex coordinate is 16 bits with 4 fractional bits. The tile index of a coordinate is the coordinate shifted right by 9 (a pixel index shifted right by 5). The bounding box spans the tile of the minimum vertex coordinate through the tile of the maximum vertex coordinate on each axis.
- R2: A candidate tile (tx,ty) covers the sample points x in [tx*512, tx*512+511] and y in [ty*512, ty*512+511]. The tile produces a record only if, for each of the three inward-facing edge functions, the maximum of that function over the tile's corners is zero or more.
- R3: For a long, thin diagonal triangle, the candidate tiles it misses produce no record, so the number of records is strictly smaller than the number of candidate tiles.
- R4: Candidates are visited in raster order: increasing column within a row, then increasing row. One candidate is visited per cycle. With out_ready held high, done is asserted exactly N+1 cycles after the input handshake, where N is the number of candidate tiles in the clamped box.
- R5: The bounding box is clamped to tile columns and rows 0..63. A triangle whose minimum tile column or minimum tile row exceeds 63 produces no record, and done follows one cycle after acceptance.
- R6: The winding is normalised. Swapping two vertices yields the same list of records.
- R7: A triangle with zero area (collinear vertices) produces no record, and done follows one cycle after acceptance.
- R8: Every record carries the primitive index captured when the triangle was accepted. Changes on in_prim after acceptance have no effect on the records.
- R9: done is a single-cycle pulse that comes after the last record. in_ready is low from acceptance until the cycle after done, so in_valid is ignored while a triangle is being binned.
- R10: While out_valid is high and out_ready is low, the record is held stable. Every expected record is delivered exactly once.
- R11: After reset, in_ready is 1, and out_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Triangle offered |
| in_ready | output | 1 | Block idle and able to accept a triangle |
| in_x0 | input | 16 | Vertex 0 X, 12.4 fixed point |
| in_y0 | input | 16 | Vertex 0 Y, 12.4 fixed point |
| in_x1 | input | 16 | Vertex 1 X |
| in_y1 | input | 16 | Vertex 1 Y |
| in_x2 | input | 16 | Vertex 2 X |
| in_y2 | input | 16 | Vertex 2 Y |
| in_prim | input | 16 | Primitive index |
| out_valid | output | 1 | Tile record valid |
| out_ready | input | 1 | Downstream accepts the record |
| out_tx | output | 6 | Tile column |
| out_ty | output | 6 | Tile row |
| out_prim | output | 16 | Primitive index of the record |
| done | output | 1 | One-cycle pulse ending a triangle's list |

## Verification
The main function is tried with several triangles:
- A small triangle inside a single tile checks that exactly one record appears, with the right coordinates.
- A large counter-clockwise triangle, and the same triangle with two vertices swapped, show whether the winding normalisation works.
- A thin diagonal triangle separates exact coverage from bounding-box coverage.
- Triangles that lie off the grid, straddle the grid edge or touch the maximum coordinate exercise the clamping.
- A collinear triangle exercises the zero-area rejection.
- A pseudo-random out_ready pattern shows that stalls lose no record and duplicate none.
- An in_valid pulse with a different primitive index during a walk shows that input offered while busy is ignored.

// File: rtl/tbin_pkg.sv
package tbin_pkg;
    localparam int COORD_W   = 16;
    localparam int FRAC_W    = 4;
    localparam int TILE_LOG2 = 5;
    localparam int GRID_LOG2 = 6;
    localparam int PRIM_W    = 16;
    localparam int TSHIFT    = TILE_LOG2 + FRAC_W;
    localparam int TILE_W    = COORD_W - TSHIFT;
    localparam int GRID_N    = 1 << GRID_LOG2;
    localparam int EW        = 2 * COORD_W + 4;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } vtx_t;

    typedef struct packed {
        coord_t                   ox;
        coord_t                   oy;
        logic signed [COORD_W:0]  dx;
        logic signed [COORD_W:0]  dy;
    } edge_t;

    typedef struct packed {
        logic [GRID_LOG2-1:0] tx;
        logic [GRID_LOG2-1:0] ty;
    } tile_t;

    function automatic edge_t mk_edge(vtx_t a, vtx_t b);
        edge_t e;
        e.ox = a.x;
        e.oy = a.y;
        e.dx = $signed({1'b0, b.x}) - $signed({1'b0, a.x});
        e.dy = $signed({1'b0, b.y}) - $signed({1'b0, a.y});
        return e;
    endfunction

    // Positive on the inner side of an edge once winding is normalised.
    function automatic logic signed [EW-1:0] edge_eval(edge_t e, coord_t px, coord_t py);
        logic signed [COORD_W:0] rx_n, ry_n;
        logic signed [EW-1:0]    rx, ry, wdx, wdy;
        rx_n = $signed({1'b0, px}) - $signed({1'b0, e.ox});
        ry_n = $signed({1'b0, py}) - $signed({1'b0, e.oy});
        rx   = EW'(rx_n);
        ry   = EW'(ry_n);
        wdx  = EW'($signed(e.dx));
        wdy  = EW'($signed(e.dy));
        return wdx * ry - wdy * rx;
    endfunction

    function automatic coord_t min3(coord_t a, coord_t b, coord_t c);
        coord_t m;
        m = (a < b) ? a : b;
        return (c < m) ? c : m;
    endfunction

    function automatic coord_t max3(coord_t a, coord_t b, coord_t c);
        coord_t m;
        m = (a > b) ? a : b;
        return (c > m) ? c : m;
    endfunction
endpackage

// File: rtl/tbin_setup.sv
module tbin_setup
    import tbin_pkg::*;
(
    input  vtx_t        v0,
    input  vtx_t        v1,
    input  vtx_t        v2,
    output edge_t [2:0] edges,
    output tile_t       lo,
    output tile_t       hi,
    output logic        empty
);
    localparam logic [TILE_W-1:0] GRID_LAST = TILE_W'(GRID_N - 1);

    logic signed [EW-1:0] area;
    vtx_t                 pb, pc;
    logic [TILE_W-1:0]    lo_rx, lo_ry, hi_rx, hi_ry;

    always_comb begin
        area = edge_eval(mk_edge(v0, v1), v2.x, v2.y);
        // Swap the last two vertices of a clockwise triangle.
        pb = area[EW-1] ? v2 : v1;
        pc = area[EW-1] ? v1 : v2;
        edges[0] = mk_edge(v0, pb);
        edges[1] = mk_edge(pb, pc);
        edges[2] = mk_edge(pc, v0);

        lo_rx = TILE_W'(min3(v0.x, v1.x, v2.x) >> TSHIFT);
        lo_ry = TILE_W'(min3(v0.y, v1.y, v2.y) >> TSHIFT);
        hi_rx = TILE_W'(max3(v0.x, v1.x, v2.x) >> TSHIFT);
        hi_ry = TILE_W'(max3(v0.y, v1.y, v2.y) >> TSHIFT);

        lo.tx = lo_rx[GRID_LOG2-1:0];
        lo.ty = lo_ry[GRID_LOG2-1:0];
        hi.tx = (hi_rx > GRID_LAST) ? GRID_LAST[GRID_LOG2-1:0] : hi_rx[GRID_LOG2-1:0];
        hi.ty = (hi_ry > GRID_LAST) ? GRID_LAST[GRID_LOG2-1:0] : hi_ry[GRID_LOG2-1:0];

        empty = (area == '0) || (lo_rx > GRID_LAST) || (lo_ry > GRID_LAST);
    end
endmodule

// File: rtl/tbin_edge_test.sv
module tbin_edge_test
    import tbin_pkg::*;
(
    input  edge_t [2:0] edges,
    input  tile_t       t,
    output logic        hit
);
    localparam coord_t SPAN = coord_t'((1 << TSHIFT) - 1);

    coord_t     x0, y0, x1, y1;
    logic [2:0] pass;

    always_comb begin
        x0 = coord_t'({t.tx, {TSHIFT{1'b0}}});
        y0 = coord_t'({t.ty, {TSHIFT{1'b0}}});
        x1 = x0 + SPAN;
        y1 = y0 + SPAN;
    end

    for (genvar i = 0; i < 3; i++) begin : g_edge
        coord_t               px, py;
        logic signed [EW-1:0] val;
        always_comb begin
            // Pick the tile corner where this edge function is largest.
            px      = ($signed(edges[i].dy) <= 0) ? x1 : x0;
            py      = ($signed(edges[i].dx) >= 0) ? y1 : y0;
            val     = edge_eval(edges[i], px, py);
            pass[i] = ~val[EW-1];
        end
    end

    assign hit = &pass;
endmodule

// File: rtl/tri_tile_binner.sv
module tri_tile_binner
    import tbin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [COORD_W-1:0]   in_x0,
    input  logic [COORD_W-1:0]   in_y0,
    input  logic [COORD_W-1:0]   in_x1,
    input  logic [COORD_W-1:0]   in_y1,
    input  logic [COORD_W-1:0]   in_x2,
    input  logic [COORD_W-1:0]   in_y2,
    input  logic [PRIM_W-1:0]    in_prim,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [GRID_LOG2-1:0] out_tx,
    output logic [GRID_LOG2-1:0] out_ty,
    output logic [PRIM_W-1:0]    out_prim,
    output logic                 done
);
    typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} state_t;

    state_t             state;
    edge_t [2:0]        set_edges, edges_q;
    tile_t              set_lo, set_hi, lo_q, hi_q, cur_q;
    logic               set_empty, hit, advance;
    logic [PRIM_W-1:0]  prim_q;

    tbin_setup u_setup (
        .v0    ('{x: in_x0, y: in_y0}),
        .v1    ('{x: in_x1, y: in_y1}),
        .v2    ('{x: in_x2, y: in_y2}),
        .edges (set_edges),
        .lo    (set_lo),
        .hi    (set_hi),
        .empty (set_empty)
    );

    tbin_edge_test u_test (
        .edges (edges_q),
        .t     (cur_q),
        .hit   (hit)
    );

    assign in_ready  = (state == S_IDLE);
    assign out_valid = (state == S_WALK) && hit;
    assign done      = (state == S_DONE);
    assign out_tx    = cur_q.tx;
    assign out_ty    = cur_q.ty;
    assign out_prim  = prim_q;
    assign advance   = !hit || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            edges_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            cur_q   <= '0;
            prim_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (in_valid) begin
                    edges_q <= set_edges;
                    lo_q    <= set_lo;
                    hi_q    <= set_hi;
                    cur_q   <= set_lo;
                    prim_q  <= in_prim;
                    state   <= set_empty ? S_DONE : S_WALK;
                end
                S_WALK: if (advance) begin
                    if (cur_q.tx == hi_q.tx) begin
                        cur_q.tx <= lo_q.tx;
                        if (cur_q.ty == hi_q.ty) state <= S_DONE;
                        else                     cur_q.ty <= cur_q.ty + 1'b1;
                    end else begin
                        cur_q.tx <= cur_q.tx + 1'b1;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_tx) && $stable(out_ty) && $stable(out_prim));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_then_ready_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> in_ready);

    p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_raster_order_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> !out_valid || (out_ty > $past(out_ty)) ||
                                   (out_ty == $past(out_ty) && out_tx > $past(out_tx)));

    p_empty_done_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && set_empty |=> done);
endmodule

// File: tb/tri_tile_binner_bench.sv
module tri_tile_binner_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0, in_x2 = '0, in_y2 = '0;
    logic [15:0] in_prim = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [5:0]  out_tx, out_ty;
    logic [15:0] out_prim;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    int exp_tx[$];
    int exp_ty[$];
    int exp_n;
    int last_got;
    int got_ccw;

    always #5 clk = ~clk;

    tri_tile_binner u_tri_tile_binner (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
        .in_x2(in_x2), .in_y2(in_y2), .in_prim(in_prim),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_tx(out_tx), .out_ty(out_ty), .out_prim(out_prim), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint ev(longint ox, longint oy, longint qx, longint qy,
                                  longint px, longint py);
        return (qx - ox) * (py - oy) - (qy - oy) * (px - ox);
    endfunction

    function automatic longint edge_max(longint ox, longint oy, longint qx, longint qy,
                                        longint x0, longint y0, longint x1, longint y1);
        longint m, v;
        m = ev(ox, oy, qx, qy, x0, y0);
        v = ev(ox, oy, qx, qy, x1, y0); if (v > m) m = v;
        v = ev(ox, oy, qx, qy, x0, y1); if (v > m) m = v;
        v = ev(ox, oy, qx, qy, x1, y1); if (v > m) m = v;
        return m;
    endfunction

    // Reference list: clamped box in raster order, corner-maximum edge test.
    task automatic build_expect(input longint ax, ay, bx, by, cx, cy);
        longint area, tx_, ty_, lox, loy, hix, hiy;
        exp_tx.delete();
        exp_ty.delete();
        exp_n = 0;
        area = ev(ax, ay, bx, by, cx, cy);
        if (area == 0) return;
        if (area < 0) begin
            tx_ = bx; ty_ = by; bx = cx; by = cy; cx = tx_; cy = ty_;
        end
        lox = ax; if (bx < lox) lox = bx; if (cx < lox) lox = cx;
        loy = ay; if (by < loy) loy = by; if (cy < loy) loy = cy;
        hix = ax; if (bx > hix) hix = bx; if (cx > hix) hix = cx;
        hiy = ay; if (by > hiy) hiy = by; if (cy > hiy) hiy = cy;
        lox = lox / 512; loy = loy / 512; hix = hix / 512; hiy = hiy / 512;
        if (lox > 63 || loy > 63) return;
        if (hix > 63) hix = 63;
        if (hiy > 63) hiy = 63;
        exp_n = int'((hix - lox + 1) * (hiy - loy + 1));
        for (longint ty = loy; ty <= hiy; ty++) begin
            for (longint tx = lox; tx <= hix; tx++) begin
                longint x0, y0, x1, y1;
                x0 = tx * 512; y0 = ty * 512; x1 = x0 + 511; y1 = y0 + 511;
                if (edge_max(ax, ay, bx, by, x0, y0, x1, y1) >= 0 &&
                    edge_max(bx, by, cx, cy, x0, y0, x1, y1) >= 0 &&
                    edge_max(cx, cy, ax, ay, x0, y0, x1, y1) >= 0) begin
                    exp_tx.push_back(int'(tx));
                    exp_ty.push_back(int'(ty));
                end
            end
        end
    endtask

    // mode 0: ready high; 1: pseudo-random ready; 2: ready high plus intruding in_valid
    task automatic run_tri(input int ax, ay, bx, by, cx, cy, input int prim,
                           input int mode, input string tag);
        int cyc, got, nexp;
        build_expect(ax, ay, bx, by, cx, cy);
        nexp = exp_tx.size();
        @(negedge clk);
        in_x0 = 16'(ax); in_y0 = 16'(ay); in_x1 = 16'(bx); in_y1 = 16'(by);
        in_x2 = 16'(cx); in_y2 = 16'(cy); in_prim = 16'(prim);
        in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R9", {tag, " in_ready when idle"}, in_ready, 1);
        @(posedge clk);
        #1 in_valid = 1'b0;
        cyc = 0;
        got = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (mode == 1) begin
                out_ready = lfsr[0] | lfsr[3];
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            end else begin
                out_ready = 1'b1;
            end
            if (mode == 2 && cyc >= 2 && cyc <= 4) begin
                in_valid = 1'b1;
                in_prim  = 16'd999;
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (done) begin
                chk(exp_tx.size() == 0, "R10", {tag, " records missing at done"}, exp_tx.size(), 0);
                chk(got == nexp, "R2", {tag, " record count"}, got, nexp);
                if (mode != 1)
                    chk(cyc == exp_n + 1, "R4", {tag, " cycles to done"}, cyc, exp_n + 1);
                break;
            end
            if (in_ready) begin
                chk(0, "R9", {tag, " in_ready high while busy"}, 1, 0);
            end
            if (out_valid && out_ready) begin
                got++;
                if (exp_tx.size() == 0) begin
                    chk(0, "R2", {tag, " unexpected record tx"}, out_tx, -1);
                end else begin
                    int etx, ety;
                    etx = exp_tx.pop_front();
                    ety = exp_ty.pop_front();
                    chk(out_tx == etx, "R1", {tag, " tile column"}, out_tx, etx);
                    chk(out_ty == ety, "R4", {tag, " tile row"}, out_ty, ety);
                    chk(out_prim == 16'(prim), "R8", {tag, " primitive index"}, out_prim, prim);
                end
            end
            if (cyc > 20000) begin
                chk(0, "R4", {tag, " done never arrived"}, cyc, exp_n + 1);
                break;
            end
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R9", {tag, " done is one cycle"}, done, 0);
        chk(in_ready == 1'b1, "R9", {tag, " ready after done"}, in_ready, 1);
        last_got = got;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1;
        chk(in_ready == 1'b1, "R11", "reset in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R11", "reset out_valid", out_valid, 0);
        chk(done == 1'b0, "R11", "reset done", done, 0);

        // R1: small triangle inside tile (1,1)
        run_tri(40*16, 40*16, 60*16, 45*16, 50*16, 60*16, 11, 0, "single_tile");
        chk(last_got == 1, "R1", "single tile count", last_got, 1);

        // R6: counter-clockwise and swapped (clockwise) copies
        run_tri(10*16, 10*16, 300*16, 40*16, 100*16, 280*16, 22, 0, "ccw");
        got_ccw = last_got;
        run_tri(10*16, 10*16, 100*16, 280*16, 300*16, 40*16, 23, 0, "cw");
        chk(last_got == got_ccw, "R6", "winding count match", last_got, got_ccw);

        // R3: long thin diagonal
        run_tri(5*16, 5*16, 1000*16, 990*16, 990*16, 1000*16, 33, 0, "thin");
        chk(last_got < exp_n, "R3", "thin emits fewer than box", last_got, exp_n);

        // R5: entirely off grid, partially off grid, max coordinate
        run_tri(2100*16, 10*16, 2200*16, 10*16, 2150*16, 100*16, 44, 0, "offgrid");
        chk(last_got == 0, "R5", "off grid emits nothing", last_got, 0);
        run_tri(1900*16, 1900*16, 3000*16, 1950*16, 1950*16, 3000*16, 45, 0, "clamp");
        run_tri(2000*16, 100*16, 65535, 300*16, 1800*16, 65535, 46, 0, "maxcoord");

        // R7: zero area
        run_tri(10*16, 10*16, 100*16, 100*16, 200*16, 200*16, 55, 0, "collinear");
        chk(last_got == 0, "R7", "zero area emits nothing", last_got, 0);

        // R10: backpressure
        run_tri(10*16, 10*16, 300*16, 40*16, 100*16, 280*16, 66, 1, "stall");
        chk(last_got == got_ccw, "R10", "stall record count", last_got, got_ccw);

        // R8/R9: in_valid with another index during a walk is ignored
        run_tri(10*16, 10*16, 300*16, 40*16, 100*16, 280*16, 77, 2, "intrude");

        // Thin triangle the other way with fractional vertices
        run_tri(1003, 20, 31000, 29000, 30500, 29400, 88, 1, "thin_frac");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule